// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a serial audio stream into parallel sample words. It runs on the system clock. It watches a bit clock, a frame clock and one data line, all already synchronised to the system clock by the caller, and treats each rising edge of the bit clock as one data bit. The block is always a slave: it never generates either serial clock.

The block handles four two-channel framings and one six-channel mode. The four framings are I2S, left-justified, right-justified and a pulse-framed mode in which a short frame pulse starts the frame and the channel words follow it back to back. In the six-channel mode, six fixed 32-bit slots share a single data line.

A two-bit width field selects the number of bits in each word. Every word is delivered left-aligned in a 24-bit output, together with a channel index and a one-cycle valid strobe. The receiver counts bit clocks and never measures time, so frames may arrive in bursts, and the bit clock may pause between bits or between frames.

Top module: `aud_serial_rx`

## Requirements
- R1: After reset, `valid` is low and both `word` and `chan` are zero. No word is produced until the frame clock has changed level at least once, as seen at a bit-clock rising edge.
- R2: The width field `wsel` selects the word width: 00 gives 24 bits, 01 gives 20, 10 gives 18 and 11 gives 16. Each received word sits in the top bits of `word`, and all unused low bits are zero.
- R3: `fmt` = 00 selects I2S. The MSB arrives on the second bit clock after a frame-clock edge. Frame clock low carries channel 0 and frame clock high carries channel 1.
- R4: `fmt` = 01 selects left-justified. The MSB arrives on the bit clock that carries the frame-clock edge. Frame clock high carries channel 0 and frame clock low carries channel 1.
- R5: `fmt` = 10 selects right-justified. Each half-frame is 32 bit clocks long, and the word's LSB falls on the 32nd bit clock of the half-frame, so the MSB falls on bit clock 32 − width (counting from 0 at the edge). The channel mapping is the same as in R4.
- R6: `fmt` = 11 selects pulse framing. Only a rising frame-clock edge starts a frame, and a falling edge is ignored. The channel 0 MSB arrives on the bit clock after the pulse, and the channel 1 word follows straight after the channel 0 LSB.
- R7: When `packed_mode` = 1, `fmt` has no effect. A rising frame-clock edge starts six 32-bit slots, and the first slot begins on the edge bit. Each word starts at the start of its slot. Slot k is delivered with `chan` = k, for k from 0 to 5.
- R8: `valid` is high for exactly one system clock cycle per completed word. That cycle is the one right after the system clock edge that detects the bit-clock rise carrying the word's last bit.
- R9: If a frame-start edge arrives before the current word is complete, that word is dropped without a `valid`, and bit counting restarts from the new edge.
- R10: Words are decoded correctly when the bit clock stalls for any number of system cycles, whether mid-word or between frames.
- R11: In every format, bits arrive MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Bit clock, already synchronised to `clk` |
| lrclk | input | 1 | Frame clock, already synchronised to `clk` |
| sdata | input | 1 | Serial data, sampled on each bit-clock rise |
| fmt | input | 2 | Framing select: 00 I2S, 01 left-justified, 10 right-justified, 11 pulse-framed |
| packed_mode | input | 1 | 1 selects six-slot single-line mode, which overrides `fmt` |
| wsel | input | 2 | Word width field (encoding as in R2) |
| word | output | 24 | Received word, left-aligned |
| chan | output | 3 | Channel index of `word` |
| valid | output | 1 | One-cycle strobe for a completed word |

## Verification
Any error in the bit position or the slot counter shows up at the ports within one word. A word shifted by one bit gives a doubled or halved value with a wrong low bit, a missed wrap gives a wrong channel index, and a spurious restart swallows a word entirely. The bench therefore uses distinctive, asymmetric sample values and compares every word with its channel in order. The strobe is checked on the exact system cycles around the final bit, so a strobe that is one cycle late or one cycle too long is caught. A falling frame edge that wrongly restarts pulse-framed or six-slot reception is caught by the missing later words.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

  localparam logic [1:0] FMT_I2S = 2'd0;
  localparam logic [1:0] FMT_LJ  = 2'd1;
  localparam logic [1:0] FMT_RJ  = 2'd2;
  localparam logic [1:0] FMT_DSP = 2'd3;

  // word width selected by the two-bit width field
  function automatic int word_bits(input logic [1:0] sel);
    case (sel)
      2'd0:    return 24;
      2'd1:    return 20;
      2'd2:    return 18;
      default: return 16;
    endcase
  endfunction

  // bit-clock index (0 = edge bit) of the MSB inside a half-frame or slot
  function automatic int first_bit(input logic [1:0] f, input logic pk,
                                   input int w, input int slot_bits);
    if (pk) return 0;
    case (f)
      FMT_I2S, FMT_DSP: return 1;
      FMT_RJ:           return slot_bits - w;
      default:          return 0;
    endcase
  endfunction

endpackage

// File: rtl/aud_rx_edge.sv
module aud_rx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic lrclk,
  output logic rise,
  output logic lr_any,
  output logic lr_up
);
  logic bclk_q;
  logic lr_prev;
  logic seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q  <= 1'b0;
      lr_prev <= 1'b0;
      seen    <= 1'b0;
    end else begin
      bclk_q <= bclk;
      if (rise) begin
        lr_prev <= lrclk;
        seen    <= 1'b1;
      end
    end
  end

  assign rise   = bclk & ~bclk_q;
  assign lr_any = rise & seen & (lrclk ^ lr_prev);
  assign lr_up  = lr_any & lrclk;

endmodule

// File: rtl/aud_rx_slot.sv
module aud_rx_slot #(
  parameter int PW = 6,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise,
  input  logic          restart,
  input  logic          multi,
  input  logic [PW-1:0] first,
  input  logic [PW-1:0] wlen,
  input  logic [PW-1:0] slen,
  input  logic [SW-1:0] last_slot,
  output logic [PW-1:0] cur_pos,
  output logic [SW-1:0] cur_slot,
  output logic          in_word,
  output logic          done
);
  logic [PW-1:0] pos_q;
  logic [SW-1:0] slot_q;
  logic          act_q;
  logic          cur_act;
  logic          wrap;
  logic [PW-1:0] last_bit;
  logic [PW-1:0] slot_end;

  always_comb begin
    cur_pos  = restart ? '0 : pos_q;
    cur_slot = restart ? '0 : slot_q;
    cur_act  = restart | act_q;
    last_bit = first + wlen - PW'(1);
    slot_end = first + slen - PW'(1);
    in_word  = rise & cur_act & (cur_pos >= first) & (cur_pos <= last_bit);
    done     = rise & cur_act & (cur_pos == last_bit);
    wrap     = multi & cur_act & (cur_pos == slot_end);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q  <= '0;
      slot_q <= '0;
      act_q  <= 1'b0;
    end else if (rise) begin
      if (wrap) begin
        pos_q <= first;
        if (cur_slot == last_slot) begin
          act_q  <= 1'b0;
          slot_q <= cur_slot;
        end else begin
          act_q  <= 1'b1;
          slot_q <= cur_slot + SW'(1);
        end
      end else begin
        act_q  <= cur_act;
        slot_q <= cur_slot;
        pos_q  <= (cur_pos == '1) ? cur_pos : cur_pos + PW'(1);
      end
    end
  end

  // R7
  slot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (slot_q <= last_slot));

  // R9
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && restart) |=> (pos_q == PW'(1)));

endmodule

// File: rtl/aud_rx_pack.sv
module aud_rx_pack #(
  parameter int WORD_W = 24,
  parameter int PW     = 6,
  parameter int CW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_word,
  input  logic              done,
  input  logic              sbit,
  input  logic [PW-1:0]     cur_pos,
  input  logic [PW-1:0]     first,
  input  logic [CW-1:0]     chan_in,
  output logic [WORD_W-1:0] word_o,
  output logic [CW-1:0]     chan_o,
  output logic              valid_o
);
  logic [WORD_W-1:0] sh;
  logic [WORD_W-1:0] sh_n;
  logic [PW-1:0]     k;

  always_comb begin
    k    = cur_pos - first;
    sh_n = sh;
    if (in_word) begin
      if (cur_pos == first) sh_n = '0;
      for (int b = 0; b < WORD_W; b++)
        if (PW'(WORD_W - 1 - b) == k) sh_n[b] = sbit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh      <= '0;
      word_o  <= '0;
      chan_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      sh      <= sh_n;
      valid_o <= done;
      if (done) begin
        word_o <= sh_n;
        chan_o <= chan_in;
      end
    end
  end

  // R8
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
  import aud_rx_pkg::*;
#(
  parameter int WORD_W    = 24,
  parameter int SLOT_BITS = 32,
  parameter int NCH       = 6,
  localparam int CW       = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk,
  input  logic              lrclk,
  input  logic              sdata,
  input  logic [1:0]        fmt,
  input  logic              packed_mode,
  input  logic [1:0]        wsel,
  output logic [WORD_W-1:0] word,
  output logic [CW-1:0]     chan,
  output logic              valid
);
  localparam int PW = $clog2(2 * SLOT_BITS);

  logic          rise, lr_any, lr_up;
  logic          multi, restart;
  logic [PW-1:0] wlen, first, slen;
  logic [CW-1:0] last_slot, cur_slot, chan_sel;
  logic [PW-1:0] cur_pos;
  logic          in_word, done;

  always_comb begin
    wlen      = PW'(word_bits(wsel));
    first     = PW'(first_bit(fmt, packed_mode, int'(wlen), SLOT_BITS));
    multi     = packed_mode | (fmt == FMT_DSP);
    slen      = packed_mode ? PW'(SLOT_BITS) : wlen;
    last_slot = packed_mode ? CW'(NCH - 1) : CW'(1);
    restart   = multi ? lr_up : lr_any;
    chan_sel  = multi ? cur_slot : CW'(lrclk ^ (fmt != FMT_I2S));
  end

  aud_rx_edge u_edge (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk),
    .rise(rise), .lr_any(lr_any), .lr_up(lr_up)
  );

  aud_rx_slot #(.PW(PW), .SW(CW)) u_slot (
    .clk(clk), .rst_n(rst_n), .rise(rise), .restart(restart), .multi(multi),
    .first(first), .wlen(wlen), .slen(slen), .last_slot(last_slot),
    .cur_pos(cur_pos), .cur_slot(cur_slot), .in_word(in_word), .done(done)
  );

  aud_rx_pack #(.WORD_W(WORD_W), .PW(PW), .CW(CW)) u_pack (
    .clk(clk), .rst_n(rst_n), .in_word(in_word), .done(done), .sbit(sdata),
    .cur_pos(cur_pos), .first(first), .chan_in(chan_sel),
    .word_o(word), .chan_o(chan), .valid_o(valid)
  );

  // R2
  zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && $past(wsel) == 2'b11) |-> (word[WORD_W-17:0] == '0));

  // R6
  pair_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !$past(packed_mode)) |-> (chan <= CW'(1)));

  // R7
  chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (chan < CW'(NCH)));

endmodule

// File: tb/tb_aud_serial_rx.sv
`timescale 1ns/1ps
module tb_aud_serial_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0;
  logic [1:0]  fmt = 2'd0;
  logic        packed_mode = 1'b0;
  logic [1:0]  wsel = 2'd0;
  logic [23:0] word;
  logic [2:0]  chan;
  logic        valid;

  int total = 0, bad = 0;
  logic [23:0] got_w [16];
  logic [2:0]  got_c [16];
  logic [23:0] ew [16];
  logic [2:0]  ec [16];
  int n_got = 0, n_exp = 0;

  always #2 clk = ~clk;

  aud_serial_rx dut (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
    .fmt(fmt), .packed_mode(packed_mode), .wsel(wsel),
    .word(word), .chan(chan), .valid(valid)
  );

  // fields: fmt[51:50] wsel[49:48] left[47:24] right[23:0]
  localparam logic [51:0] TAB [9] = '{
    {2'd0, 2'd0, 24'hA5C3F1, 24'h1234AB},
    {2'd0, 2'd3, 24'hFFFFFF, 24'h800001},
    {2'd1, 2'd1, 24'hC0FFEE, 24'h0F0F0F},
    {2'd1, 2'd2, 24'h9ABCDE, 24'h7FFFFF},
    {2'd2, 2'd0, 24'h13579B, 24'hECA864},
    {2'd2, 2'd3, 24'hF00DCA, 24'h00FF00},
    {2'd2, 2'd1, 24'h5A5A5A, 24'hA5A5A5},
    {2'd3, 2'd0, 24'hDEAD01, 24'h2468AC},
    {2'd3, 2'd3, 24'h8001FF, 24'h7FFE00}
  };

  always @(negedge clk)
    if (valid && n_got < 16) begin
      got_w[n_got] = word;
      got_c[n_got] = chan;
      n_got++;
    end

  function automatic int bw(input logic [1:0] s);
    case (s)
      2'd0: return 24;
      2'd1: return 20;
      2'd2: return 18;
      default: return 16;
    endcase
  endfunction

  function automatic logic [23:0] trunc(input logic [23:0] v, input int w);
    logic [23:0] m;
    m = 24'hFFFFFF << (24 - w);
    return v & m;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic verify(input string req);
    chk(n_got == n_exp, {req, " word count"}, n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      chk(got_w[i] == ew[i], {req, " word"}, got_w[i], ew[i]);
      chk(got_c[i] == ec[i], {req, " chan"}, got_c[i], ec[i]);
    end
    n_got = 0;
    n_exp = 0;
  endtask

  task automatic push(input logic [23:0] w, input logic [2:0] c);
    ew[n_exp] = w;
    ec[n_exp] = c;
    n_exp++;
  endtask

  task automatic send_bit(input logic l, input logic d);
    bclk = 1'b0; lrclk = l; sdata = d;
    repeat (2) begin @(posedge clk); #1; end
    bclk = 1'b1;
    repeat (2) begin @(posedge clk); #1; end
  endtask

  task automatic send_frame(input logic [1:0] f, input logic [1:0] s,
                            input logic [23:0] lv, input logic [23:0] rv);
    int w;
    int st;
    logic ll;
    logic [23:0] v;
    w = bw(s);
    if (f == 2'd3) begin
      send_bit(1'b0, 1'b0); send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0);
      for (int i = 0; i < 2 * w; i++)
        send_bit(1'b0, i < w ? lv[23 - i] : rv[23 - (i - w)]);
      send_bit(1'b0, 1'b0);
    end else begin
      ll = (f == 2'd0) ? 1'b0 : 1'b1;
      st = (f == 2'd0) ? 1 : (f == 2'd1) ? 0 : 32 - w;
      send_bit(~ll, 1'b0); send_bit(~ll, 1'b0);
      for (int h = 0; h < 2; h++) begin
        v = (h == 0) ? lv : rv;
        for (int j = 0; j < 32; j++)
          send_bit(h == 0 ? ll : ~ll,
                   (j >= st && j < st + w) ? v[23 - (j - st)] : 1'b0);
      end
    end
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [23:0] pv [6];
    logic [23:0] tv;
    pv = '{24'h111111, 24'h2A2B2C, 24'hC33C3C, 24'h4DD4D4, 24'h5E5EE5, 24'hF6F66F};
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(valid == 1'b0, "R1 valid after reset", valid, 0);
    chk(word == 24'h0, "R1 word after reset", word, 0);
    chk(chan == 3'd0, "R1 chan after reset", chan, 0);
    @(posedge clk); #1;
    // R1 no word without a frame-clock change
    fmt = 2'd1;
    for (int i = 0; i < 40; i++) send_bit(1'b1, 1'b1);
    verify("R1 no edge");

    // table walk: R3 R4 R5 R6 with R2 widths and R11 bit order
    for (int t = 0; t < 9; t++) begin
      fmt  = TAB[t][51:50];
      wsel = TAB[t][49:48];
      send_frame(fmt, wsel, TAB[t][47:24], TAB[t][23:0]);
      push(trunc(TAB[t][47:24], bw(wsel)), 3'd0);
      push(trunc(TAB[t][23:0], bw(wsel)), 3'd1);
      case (fmt)
        2'd0: verify("R3 R2 R11 i2s");
        2'd1: verify("R4 R2 R11 left-just");
        2'd2: verify("R5 R2 R11 right-just");
        default: verify("R6 R2 R11 pulse-framed");
      endcase
    end

    // R7 six slots, fmt ignored
    for (int p = 0; p < 2; p++) begin
      packed_mode = 1'b1; fmt = 2'd1; wsel = (p == 0) ? 2'd0 : 2'd2;
      send_bit(1'b0, 1'b0); send_bit(1'b0, 1'b0);
      for (int j = 0; j < 192; j++)
        send_bit(j < 96, (j % 32) < bw(wsel) ? pv[j / 32][23 - (j % 32)] : 1'b0);
      send_bit(1'b0, 1'b0);
      for (int k = 0; k < 6; k++) push(trunc(pv[k], bw(wsel)), 3'(k));
      verify("R7 six-slot");
    end
    packed_mode = 1'b0;

    // R9 early frame edge drops the partial word
    fmt = 2'd0; wsel = 2'd0;
    send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0);
    send_bit(1'b0, 1'b0);
    for (int j = 0; j < 10; j++) send_bit(1'b0, 1'b1);
    tv = 24'h6C3A91;
    for (int j = 0; j < 32; j++)
      send_bit(1'b1, (j >= 1 && j <= 24) ? tv[24 - j] : 1'b0);
    push(tv, 3'd1);
    verify("R9 abort");

    // R8 strobe timing around the last bit
    fmt = 2'd1; wsel = 2'd3; tv = 24'hBEEF42;
    send_bit(1'b0, 1'b0); send_bit(1'b0, 1'b0);
    for (int j = 0; j < 15; j++) send_bit(1'b1, tv[23 - j]);
    bclk = 1'b0; lrclk = 1'b1; sdata = tv[8];
    repeat (2) begin @(posedge clk); #1; end
    bclk = 1'b1;
    @(negedge clk);
    chk(valid == 1'b0, "R8 strobe not early", valid, 0);
    @(negedge clk);
    chk(valid == 1'b1, "R8 strobe cycle", valid, 1);
    chk(word == 24'hBEEF00, "R8 R2 word at strobe", word, 24'hBEEF00);
    @(negedge clk);
    chk(valid == 1'b0, "R8 strobe one cycle", valid, 0);
    for (int j = 16; j < 32; j++) send_bit(1'b1, 1'b0);
    for (int j = 0; j < 32; j++) send_bit(1'b0, 1'b0);
    push(24'hBEEF00, 3'd0);
    push(24'h000000, 3'd1);
    verify("R8 frame");

    // R10 stalled bit clock
    fmt = 2'd1; wsel = 2'd1; tv = 24'h3C96A5;
    send_bit(1'b0, 1'b0); send_bit(1'b0, 1'b0);
    repeat (100) @(posedge clk);
    #1;
    for (int j = 0; j < 32; j++) begin
      if (j == 5) begin repeat (40) @(posedge clk); #1; end
      send_bit(1'b1, j < 20 ? tv[23 - j] : 1'b0);
    end
    repeat (100) @(posedge clk);
    #1;
    for (int j = 0; j < 32; j++) send_bit(1'b0, j < 20 ? ~tv[23 - j] : 1'b0);
    push(trunc(tv, 20), 3'd0);
    push(trunc(~tv, 20), 3'd1);
    verify("R10 burst");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule